// File: doc/BRIEF.md
# Store Set Memory Dependence Predictor

This block decides, at fetch time, whether a load or store has to hold back behind an older store that is still in flight, and which store that is. Each instruction address maps to a store set identifier through an address-indexed table of identifiers. A second table, indexed by identifier, holds the tag of the youngest fetched store of that set that has not yet issued. A load that has never caused an ordering violation has no identifier and goes ahead freely. Once it has been caught reading ahead of a store it depended on, it and that store share an identifier, and from then on it waits.

Three update paths act on the tables. The violation path trains the identifier table from a load address and a store address, merging sets under a fixed rule. The issue path frees a set's last-store slot once that store leaves. A programmable interval timer wipes both tables from time to time, so that stale aliasing and runaway merging do not build up. Stores in one set chain through the last-store slot and therefore issue in fetch order.

Top module: `store_set_pred`

## Requirements
- R1: After reset every table entry is empty, so no fetched load or store is told to wait.
- R2: A fetched load whose address has no store set gets wait_o = 0.
- R3: A violation in which neither address has an identifier gives both the identifier equal to the low SSID_W bits of the load's table index.
- R4: A violation in which only one address has an identifier copies that identifier to the other address.
- R5: A violation in which both addresses have identifiers gives both the numerically smaller one; other members of the larger set keep their identifier.
- R6: A fetched store with an identifier waits on its set's recorded store when that slot is valid, and its own tag becomes the set's recorded store from the next cycle.
- R7: An issued store empties its set's slot only when the recorded tag equals the issued tag; a mismatching issue leaves the slot unchanged.
- R8: When clr_interval_i is nonzero, both tables are emptied once every clr_interval_i cycles; a value of 0 turns the clearing off.
- R9: A fetched store with no identifier gets wait_o = 0 and leaves the last-store table untouched.
- R10: The table index is PC bits [BYTE_OFF+IDX_W-1:BYTE_OFF] (bits 7:2 by default); addresses that differ only in the byte offset, or by a multiple of 4*2^IDX_W, share an entry.
- R11: wait_tag_o carries the recorded store tag whenever wait_o = 1 and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_valid_i | input | 1 | A load or store is fetched this cycle |
| fetch_pc_i | input | PC_W | Address of the fetched instruction |
| fetch_is_store_i | input | 1 | 1 for a store, 0 for a load |
| fetch_tag_i | input | TAG_W | In-flight tag of the fetched instruction |
| wait_o | output | 1 | Fetched instruction must wait on an older store |
| wait_tag_o | output | TAG_W | Tag of the store to wait on |
| issue_valid_i | input | 1 | A store issues this cycle |
| issue_pc_i | input | PC_W | Address of the issued store |
| issue_tag_i | input | TAG_W | Tag of the issued store |
| viol_valid_i | input | 1 | An ordering violation is reported |
| viol_load_pc_i | input | PC_W | Address of the load that read too early |
| viol_store_pc_i | input | PC_W | Address of the store it should have waited for |
| clr_interval_i | input | CLR_W | Cycles between table wipes, 0 disables |

## Verification
The fetch response is tried with loads and stores that have no set, with sets built from scratch, by copying one side's identifier and by merging two populated sets, so that the bench can tell which merge branch chose which identifier: after a merge only a store from the smaller set blocks the load. Chains of two stores in one set show that the second waits on the first and the load waits on the younger one. Issues with a stale tag and then a matching tag separate a guarded release from an unconditional one. Aliased addresses and a timed wipe show the indexing and the clearing period, and a disabled timer shows that training survives long idle stretches.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  typedef enum logic [1:0] {
    MRG_NEW   = 2'd0,
    MRG_TO_LD = 2'd1,
    MRG_TO_ST = 2'd2,
    MRG_MIN   = 2'd3
  } merge_e;

  function automatic logic [15:0] min16(input logic [15:0] a, input logic [15:0] b);
    return (a < b) ? a : b;
  endfunction
endpackage

// File: rtl/ssp_clear_timer.sv
module ssp_clear_timer #(
  parameter int unsigned CLR_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CLR_W-1:0] interval_i,
  output logic             clr_o
);
  logic [CLR_W-1:0] cnt_q;
  logic             on;

  assign on    = (interval_i != '0);
  assign clr_o = on && (cnt_q >= interval_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (!on)   cnt_q <= '0;
    else if (clr_o) cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

  assert_clr_gap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_o && (interval_i > 1) && $stable(interval_i) |=> !clr_o || !$stable(interval_i));
endmodule

// File: rtl/ssp_ssit.sv
module ssp_ssit
  import ssp_pkg::*;
#(
  parameter int unsigned IDX_W  = 6,
  parameter int unsigned SSID_W = 4,
  parameter int unsigned NRD    = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         clear_i,
  input  logic [NRD-1:0][IDX_W-1:0]    rd_idx_i,
  output logic [NRD-1:0]               rd_vld_o,
  output logic [NRD-1:0][SSID_W-1:0]   rd_id_o,
  input  logic                         viol_i,
  input  logic [IDX_W-1:0]             ld_idx_i,
  input  logic [IDX_W-1:0]             st_idx_i
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0]  vld_q;
  logic [SSID_W-1:0] id_q [DEPTH];

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd_vld_o[p] = vld_q[rd_idx_i[p]];
    assign rd_id_o[p]  = id_q[rd_idx_i[p]];
  end

  logic              ld_v, st_v;
  logic [SSID_W-1:0] ld_id, st_id, new_id;
  merge_e            mode;

  assign ld_v  = vld_q[ld_idx_i];
  assign st_v  = vld_q[st_idx_i];
  assign ld_id = id_q[ld_idx_i];
  assign st_id = id_q[st_idx_i];

  always_comb begin
    unique case ({ld_v, st_v})
      2'b00:   mode = MRG_NEW;
      2'b01:   mode = MRG_TO_LD;
      2'b10:   mode = MRG_TO_ST;
      default: mode = MRG_MIN;
    endcase
    unique case (mode)
      MRG_NEW:   new_id = ld_idx_i[SSID_W-1:0];
      MRG_TO_LD: new_id = st_id;
      MRG_TO_ST: new_id = ld_id;
      default:   new_id = SSID_W'(min16(16'(ld_id), 16'(st_id)));
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      for (int i = 0; i < DEPTH; i++) id_q[i] <= '0;
    end else if (clear_i) begin
      vld_q <= '0;
    end else if (viol_i) begin
      vld_q[ld_idx_i] <= 1'b1;
      vld_q[st_idx_i] <= 1'b1;
      id_q[ld_idx_i]  <= new_id;
      id_q[st_idx_i]  <= new_id;
    end
  end

  assert_merge_same_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_i && !clear_i |=> vld_q[$past(ld_idx_i)] && vld_q[$past(st_idx_i)] &&
                           id_q[$past(ld_idx_i)] == id_q[$past(st_idx_i)]);

  assert_merge_min_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_i && !clear_i && ld_v && st_v |=>
      id_q[$past(st_idx_i)] == (($past(ld_id) < $past(st_id)) ? $past(ld_id) : $past(st_id)));

  assert_clear_all_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> $countones(vld_q) == 0);
endmodule

// File: rtl/ssp_lfst.sv
module ssp_lfst #(
  parameter int unsigned SSID_W = 4,
  parameter int unsigned TAG_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic [SSID_W-1:0] rd_id_i,
  output logic              rd_vld_o,
  output logic [TAG_W-1:0]  rd_tag_o,
  input  logic              wr_en_i,
  input  logic [SSID_W-1:0] wr_id_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic              inv_en_i,
  input  logic [SSID_W-1:0] inv_id_i,
  input  logic [TAG_W-1:0]  inv_tag_i
);
  localparam int unsigned NSET = 1 << SSID_W;

  logic [NSET-1:0] vld_q;
  logic [TAG_W-1:0] tag_q [NSET];

  assign rd_vld_o = vld_q[rd_id_i];
  assign rd_tag_o = tag_q[rd_id_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      for (int s = 0; s < NSET; s++) tag_q[s] <= '0;
    end else if (clear_i) begin
      vld_q <= '0;
    end else begin
      // issue release first, so a same-cycle fetch write wins
      if (inv_en_i && vld_q[inv_id_i] && tag_q[inv_id_i] == inv_tag_i)
        vld_q[inv_id_i] <= 1'b0;
      if (wr_en_i) begin
        vld_q[wr_id_i] <= 1'b1;
        tag_q[wr_id_i] <= wr_tag_i;
      end
    end
  end

  assert_store_last_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !clear_i |=> vld_q[$past(wr_id_i)] && tag_q[$past(wr_id_i)] == $past(wr_tag_i));

  assert_issue_keep_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_en_i && !clear_i && vld_q[inv_id_i] && tag_q[inv_id_i] != inv_tag_i
      |=> vld_q[$past(inv_id_i)]);

  assert_issue_free_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_en_i && !clear_i && vld_q[inv_id_i] && tag_q[inv_id_i] == inv_tag_i &&
    !(wr_en_i && wr_id_i == inv_id_i) |=> !vld_q[$past(inv_id_i)]);

  assert_clear_all_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> vld_q == '0);
endmodule

// File: rtl/store_set_pred.sv
module store_set_pred #(
  parameter int unsigned PC_W     = 32,
  parameter int unsigned TAG_W    = 6,
  parameter int unsigned IDX_W    = 6,
  parameter int unsigned SSID_W   = 4,
  parameter int unsigned BYTE_OFF = 2,
  parameter int unsigned CLR_W    = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_valid_i,
  input  logic [PC_W-1:0]   fetch_pc_i,
  input  logic              fetch_is_store_i,
  input  logic [TAG_W-1:0]  fetch_tag_i,
  output logic              wait_o,
  output logic [TAG_W-1:0]  wait_tag_o,
  input  logic              issue_valid_i,
  input  logic [PC_W-1:0]   issue_pc_i,
  input  logic [TAG_W-1:0]  issue_tag_i,
  input  logic              viol_valid_i,
  input  logic [PC_W-1:0]   viol_load_pc_i,
  input  logic [PC_W-1:0]   viol_store_pc_i,
  input  logic [CLR_W-1:0]  clr_interval_i
);
  localparam int unsigned IDX_HI = BYTE_OFF + IDX_W;
  localparam int unsigned RD_F   = 0;
  localparam int unsigned RD_I   = 1;

  logic unused_pc_bits;
  assign unused_pc_bits = ^{fetch_pc_i[PC_W-1:IDX_HI], fetch_pc_i[BYTE_OFF-1:0],
                            issue_pc_i[PC_W-1:IDX_HI], issue_pc_i[BYTE_OFF-1:0],
                            viol_load_pc_i[PC_W-1:IDX_HI], viol_load_pc_i[BYTE_OFF-1:0],
                            viol_store_pc_i[PC_W-1:IDX_HI], viol_store_pc_i[BYTE_OFF-1:0]};

  logic                       clr;
  logic [1:0][IDX_W-1:0]      rd_idx;
  logic [1:0]                 rd_vld;
  logic [1:0][SSID_W-1:0]     rd_id;
  logic                       lf_vld;
  logic [TAG_W-1:0]           lf_tag;

  assign rd_idx[RD_F] = fetch_pc_i[IDX_HI-1:BYTE_OFF];
  assign rd_idx[RD_I] = issue_pc_i[IDX_HI-1:BYTE_OFF];

  ssp_clear_timer #(.CLR_W(CLR_W)) u_timer (
    .clk_i, .rst_ni, .interval_i(clr_interval_i), .clr_o(clr)
  );

  ssp_ssit #(.IDX_W(IDX_W), .SSID_W(SSID_W), .NRD(2)) u_ssit (
    .clk_i, .rst_ni,
    .clear_i  (clr),
    .rd_idx_i (rd_idx),
    .rd_vld_o (rd_vld),
    .rd_id_o  (rd_id),
    .viol_i   (viol_valid_i),
    .ld_idx_i (viol_load_pc_i[IDX_HI-1:BYTE_OFF]),
    .st_idx_i (viol_store_pc_i[IDX_HI-1:BYTE_OFF])
  );

  ssp_lfst #(.SSID_W(SSID_W), .TAG_W(TAG_W)) u_lfst (
    .clk_i, .rst_ni,
    .clear_i   (clr),
    .rd_id_i   (rd_id[RD_F]),
    .rd_vld_o  (lf_vld),
    .rd_tag_o  (lf_tag),
    .wr_en_i   (fetch_valid_i && fetch_is_store_i && rd_vld[RD_F]),
    .wr_id_i   (rd_id[RD_F]),
    .wr_tag_i  (fetch_tag_i),
    .inv_en_i  (issue_valid_i && rd_vld[RD_I]),
    .inv_id_i  (rd_id[RD_I]),
    .inv_tag_i (issue_tag_i)
  );

  assign wait_o     = fetch_valid_i && rd_vld[RD_F] && lf_vld;
  assign wait_tag_o = wait_o ? lf_tag : '0;

  assert_empty_no_wait_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_valid_i && !rd_vld[RD_F] |-> !wait_o);

  assert_tag_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wait_o |-> wait_tag_o == '0);
endmodule

// File: tb/sim_store_set_pred.sv
`timescale 1ns/1ps
module sim_store_set_pred;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        fetch_valid_i = 1'b0;
  logic [31:0] fetch_pc_i = '0;
  logic        fetch_is_store_i = 1'b0;
  logic [5:0]  fetch_tag_i = '0;
  logic        wait_o;
  logic [5:0]  wait_tag_o;
  logic        issue_valid_i = 1'b0;
  logic [31:0] issue_pc_i = '0;
  logic [5:0]  issue_tag_i = '0;
  logic        viol_valid_i = 1'b0;
  logic [31:0] viol_load_pc_i = '0;
  logic [31:0] viol_store_pc_i = '0;
  logic [19:0] clr_interval_i = '0;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk_i = ~clk_i;

  store_set_pred u0 (.*);

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    fetch_valid_i = 0; issue_valid_i = 0; viol_valid_i = 0; clr_interval_i = '0;
    repeat (2) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic fetch(input logic [31:0] pc, input logic st, input logic [5:0] tag,
                       input logic ew, input logic [5:0] et, input string rq);
    @(negedge clk_i);
    fetch_valid_i = 1; fetch_pc_i = pc; fetch_is_store_i = st; fetch_tag_i = tag;
    #1;
    n_chk++;
    if (wait_o !== ew || wait_tag_o !== (ew ? et : 6'd0)) begin
      n_bad++;
      $display("FAIL %s pc=%h wait=%b tag=%0d expected wait=%b tag=%0d",
               rq, pc, wait_o, wait_tag_o, ew, ew ? et : 6'd0);
    end
    @(posedge clk_i); #1;
    fetch_valid_i = 0;
  endtask

  task automatic viol(input logic [31:0] lpc, input logic [31:0] spc);
    @(negedge clk_i);
    viol_valid_i = 1; viol_load_pc_i = lpc; viol_store_pc_i = spc;
    @(posedge clk_i); #1;
    viol_valid_i = 0;
  endtask

  task automatic issue(input logic [31:0] pc, input logic [5:0] tag);
    @(negedge clk_i);
    issue_valid_i = 1; issue_pc_i = pc; issue_tag_i = tag;
    @(posedge clk_i); #1;
    issue_valid_i = 0;
  endtask

  task automatic t_reset();   // R1
    do_reset();
    fetch(32'h0C, 0, 6'd1, 0, 0, "R1 load after reset");
    fetch(32'h40, 1, 6'd2, 0, 0, "R1 store after reset");
  endtask

  task automatic t_empty();   // R2, R9
    do_reset();
    fetch(32'h40, 1, 6'd3, 0, 0, "R9 setless store");
    fetch(32'h0C, 0, 6'd4, 0, 0, "R2 setless load");
    viol(32'h0C, 32'h40);
    fetch(32'h44, 1, 6'd5, 0, 0, "R9 other setless store");
    fetch(32'h0C, 0, 6'd6, 0, 0, "R9 setless store left slot empty");
  endtask

  task automatic t_new_set(); // R3, R11
    do_reset();
    viol(32'h0C, 32'h40);
    fetch(32'h40, 1, 6'd7, 0, 0, "R3 first store in new set");
    fetch(32'h0C, 0, 6'd8, 1, 6'd7, "R3 R11 load waits on store");
    fetch(32'h14, 0, 6'd9, 0, 0, "R2 untrained load");
  endtask

  task automatic t_copy();    // R4
    do_reset();
    viol(32'h0C, 32'h40);
    viol(32'h0C, 32'h48);
    fetch(32'h48, 1, 6'd9, 0, 0, "R4 store got load id, slot empty");
    fetch(32'h0C, 0, 6'd10, 1, 6'd9, "R4 load waits on copied store");
    viol(32'h14, 32'h40);
    fetch(32'h14, 0, 6'd11, 1, 6'd9, "R4 load took store id");
  endtask

  task automatic t_merge();   // R5
    do_reset();
    viol(32'h0C, 32'h40);     // set 3
    viol(32'h14, 32'h44);     // set 5
    viol(32'h14, 32'h40);     // merge -> 3
    fetch(32'h44, 1, 6'd10, 0, 0, "R5 larger set store");
    fetch(32'h14, 0, 6'd12, 0, 0, "R5 load moved to smaller set");
    fetch(32'h40, 1, 6'd11, 0, 0, "R5 smaller set store");
    fetch(32'h14, 0, 6'd13, 1, 6'd11, "R5 load waits in smaller set");
    fetch(32'h0C, 0, 6'd14, 1, 6'd11, "R5 original member shares set");
  endtask

  task automatic t_chain();   // R6, R7
    do_reset();
    viol(32'h0C, 32'h40);
    viol(32'h0C, 32'h48);
    fetch(32'h40, 1, 6'd20, 0, 0, "R6 first store");
    fetch(32'h48, 1, 6'd21, 1, 6'd20, "R6 second store waits on first");
    fetch(32'h0C, 0, 6'd22, 1, 6'd21, "R6 load waits on youngest");
    issue(32'h40, 6'd20);
    fetch(32'h0C, 0, 6'd23, 1, 6'd21, "R7 stale issue ignored");
    issue(32'h48, 6'd21);
    fetch(32'h0C, 0, 6'd24, 0, 0, "R7 matching issue frees slot");
  endtask

  task automatic t_clear();   // R8
    do_reset();
    clr_interval_i = 20'd20;
    viol(32'h0C, 32'h40);
    fetch(32'h40, 1, 6'd30, 0, 0, "R8 store before wipe");
    fetch(32'h0C, 0, 6'd31, 1, 6'd30, "R8 waits before wipe");
    repeat (25) @(posedge clk_i);
    fetch(32'h0C, 0, 6'd32, 0, 0, "R8 wiped after interval");
    fetch(32'h40, 1, 6'd33, 0, 0, "R8 store set wiped");
    clr_interval_i = '0;
    viol(32'h0C, 32'h40);
    fetch(32'h40, 1, 6'd34, 0, 0, "R8 store with timer off");
    repeat (60) @(posedge clk_i);
    fetch(32'h0C, 0, 6'd35, 1, 6'd34, "R8 interval 0 keeps tables");
  endtask

  task automatic t_alias();   // R10
    do_reset();
    viol(32'h0C, 32'h40);
    fetch(32'h40, 1, 6'd5, 0, 0, "R10 store");
    fetch(32'h0E, 0, 6'd6, 1, 6'd5, "R10 byte offset ignored");
    fetch(32'h10C, 0, 6'd7, 1, 6'd5, "R10 index wraps");
    fetch(32'h10, 0, 6'd8, 0, 0, "R10 neighbour entry separate");
  endtask

  initial begin
    t_reset();
    t_empty();
    t_new_set();
    t_copy();
    t_merge();
    t_chain();
    t_clear();
    t_alias();
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired got=running expected=done");
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule